// File: doc/BRIEF.md
# Cascadable Serial Segment Data Loader

This block takes display segment data one bit at a time and presents it as a 38-bit parallel word. A serial clock, an active-low chip select, a serial data line and an active-high load strobe are sampled in the fast system clock domain, and their edges are detected synchronously. On each falling edge of the serial clock, while the chip is selected, the data bit enters a 38-stage shift register. A load stage copies the register into the segment word on every system clock for as long as the strobe is high and the chip is selected. This makes it transparent for the whole pulse.

Three positions of the shift register (30, 32 and 38) are registered onto serial outputs on the rising edge of the serial clock. That is half a serial period after the shift. Any of these outputs can drive the data input of a following loader, so that longer displays can be built from a chain of loaders.

Top module: `seg_loader`

## Requirements
- R1: After the asynchronous active-low reset, the segment word and all three tap outputs are zero.
- R2: A falling edge on `ser_clk_i` while `sel_ni` is low shifts the register: position 1 takes `ser_dat_i` and position n moves to position n+1. The register updates on the first system clock edge that sees the serial clock low after it was high.
- R3: A falling edge of `ser_clk_i` while `sel_ni` is high leaves the register unchanged.
- R4: While `load_i` is high and `sel_ni` is low, `seg_o` takes the register contents on every system clock, one cycle after the register value. Bit k-1 of `seg_o` holds register position k.
- R5: A pulse on `load_i` while `sel_ni` is high leaves `seg_o` unchanged.
- R6: While `load_i` is low, `seg_o` holds its value whatever happens on the serial inputs.
- R7: `tap30_o`, `tap32_o` and `tap38_o` take register positions 30, 32 and 38 on a rising edge of `ser_clk_i` and stay stable at all other times, including across falling edges.
- R8: A bit shifted in first appears on `tap38_o` after the 38th falling edge and the following rising edge, and not earlier.
- R9: When a shift and a load fall in the same system cycle, `seg_o` takes the register contents from before the shift in that cycle, and the shifted contents one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock, sampled; shift on falling edge |
| sel_ni | input | 1 | Chip select, active low |
| ser_dat_i | input | 1 | Serial data in |
| load_i | input | 1 | Load strobe, active high, transparent while high |
| seg_o | output | 38 | Parallel segment word |
| tap30_o | output | 1 | Register position 30, updated on serial rising edge |
| tap32_o | output | 1 | Register position 32, updated on serial rising edge |
| tap38_o | output | 1 | Register position 38, updated on serial rising edge |

## Verification
A shift and a load can land in the same system cycle when the serial clock falls while the load strobe is already high. The bench provokes this case by lowering the serial clock and raising the strobe at the same drive point. It then samples the segment word twice. The first sample must equal the pre-shift register contents, and the sample one cycle later must equal the shifted contents.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int SEG_W = 38;
  localparam int TAP_N = 3;
endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_q_o,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign lvl_q_o = lvl_q;
  assign rise_o  = lvl_i & ~lvl_q;
  assign fall_o  = ~lvl_i & lvl_q;
endmodule

// File: rtl/seg_shift_reg.sv
module seg_shift_reg #(
  parameter int W = 38
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] q_o
);
  // index 0 is position 1, filled first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= {q_o[W-2:0], din_i};
  end
endmodule

// File: rtl/seg_load_stage.sv
module seg_load_stage #(
  parameter int W = 38
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/seg_tap_out.sv
module seg_tap_out #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o[g] <= 1'b0;
      else if (en_i) q_o[g] <= d_i[g];
    end
  end
endmodule

// File: rtl/seg_loader.sv
module seg_loader #(
  parameter int SEG_W = seg_pkg::SEG_W,
  parameter int TAP_A = 30,
  parameter int TAP_B = 32,
  parameter int TAP_C = SEG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_clk_i,
  input  logic             sel_ni,
  input  logic             ser_dat_i,
  input  logic             load_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             tap30_o,
  output logic             tap32_o,
  output logic             tap38_o
);
  localparam int TAP_N = seg_pkg::TAP_N;

  logic             ser_clk_q, ser_rise, ser_fall;
  logic [SEG_W-1:0] sreg;
  logic [TAP_N-1:0] tap_d, tap_q;

  seg_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (ser_clk_i),
    .lvl_q_o (ser_clk_q),
    .rise_o  (ser_rise),
    .fall_o  (ser_fall)
  );

  seg_shift_reg #(.W(SEG_W)) u_sreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ser_fall & ~sel_ni),
    .din_i  (ser_dat_i),
    .q_o    (sreg)
  );

  seg_load_stage #(.W(SEG_W)) u_load (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (load_i & ~sel_ni),
    .d_i    (sreg),
    .q_o    (seg_o)
  );

  assign tap_d = {sreg[TAP_C-1], sreg[TAP_B-1], sreg[TAP_A-1]};

  seg_tap_out #(.N(TAP_N)) u_tap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ser_rise),
    .d_i    (tap_d),
    .q_o    (tap_q)
  );

  assign tap30_o = tap_q[0];
  assign tap32_o = tap_q[1];
  assign tap38_o = tap_q[2];
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk #(
  parameter int SEG_W = 38,
  parameter int TAP_A = 30,
  parameter int TAP_B = 32,
  parameter int TAP_C = 38
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cl_i,
  input logic             cl_q_i,
  input logic             cs_ni,
  input logic             din_i,
  input logic             ld_i,
  input logic [SEG_W-1:0] sreg_i,
  input logic [SEG_W-1:0] seg_i,
  input logic [2:0]       taps_i
);
  logic fall, rise;
  assign fall = cl_q_i & ~cl_i;
  assign rise = ~cl_q_i & cl_i;

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |=> (seg_i == '0 && taps_i == '0) || !rst_ni);

  a_r2_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !cs_ni) |=> sreg_i == {$past(sreg_i[SEG_W-2:0]), $past(din_i)});

  a_r3_deselect_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(fall && !cs_ni)) |=> $stable(sreg_i));

  a_r4_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !cs_ni) |=> seg_i == $past(sreg_i));

  a_r5_r6_seg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i || cs_ni) |=> $stable(seg_i));

  a_r7_tap_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> taps_i == {$past(sreg_i[TAP_C-1]), $past(sreg_i[TAP_B-1]), $past(sreg_i[TAP_A-1])});

  a_r7_tap_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> $stable(taps_i));
endmodule

bind seg_loader seg_loader_chk #(
  .SEG_W(SEG_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cl_i   (ser_clk_i),
  .cl_q_i (ser_clk_q),
  .cs_ni  (sel_ni),
  .din_i  (ser_dat_i),
  .ld_i   (load_i),
  .sreg_i (sreg),
  .seg_i  (seg_o),
  .taps_i ({tap38_o, tap32_o, tap30_o})
);

// File: tb/tb_seg_loader.sv
module tb_seg_loader;
  localparam int CLK_P = 10;
  localparam int W = 38;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cl = 1'b1, cs_n = 1'b1, din = 1'b0, ld = 1'b0;
  logic [W-1:0] seg;
  logic t30, t32, t38;

  logic [W-1:0] sr_m, seg_m, pre_m;
  logic [2:0]   tap_m;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_loader dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(cl), .sel_ni(cs_n),
    .ser_dat_i(din), .load_i(ld), .seg_o(seg),
    .tap30_o(t30), .tap32_o(t32), .tap38_o(t38)
  );

  function automatic logic [2:0] taps_of(logic [W-1:0] s);
    return {s[37], s[31], s[29]};
  endfunction

  task automatic chk_seg(string tag, logic [W-1:0] exp);
    checks++;
    if (seg !== exp) begin
      errors++;
      $display("FAIL %s seg act=%h exp=%h", tag, seg, exp);
    end
  endtask

  task automatic chk_tap(string tag, logic [2:0] exp);
    checks++;
    if ({t38, t32, t30} !== exp) begin
      errors++;
      $display("FAIL %s taps act=%b exp=%b", tag, {t38, t32, t30}, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one serial bit: fall phase then rise phase
  task automatic shift_bit(logic b, logic sel_n);
    cs_n = sel_n; din = b; cl = 1'b0;
    wait_n(3);
    if (!sel_n) sr_m = {sr_m[W-2:0], b};
    chk_tap("R7", tap_m);  // no change across falling edge
    cl = 1'b1;
    wait_n(3);
    tap_m = taps_of(sr_m);
    chk_tap("R7", tap_m);
  endtask

  task automatic load_pulse(logic sel_n);
    cs_n = sel_n; ld = 1'b1;
    wait_n(3);
    ld = 1'b0;
    if (!sel_n) seg_m = sr_m;
    wait_n(1);
    cs_n = 1'b0;
    chk_seg(sel_n ? "R5" : "R4", seg_m);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1577));
    sr_m = '0; seg_m = '0; tap_m = '0;
    wait_n(3);
    chk_seg("R1", '0);
    chk_tap("R1", '0);
    rst_n = 1'b1;
    wait_n(2);
    chk_seg("R1", '0);
    chk_tap("R1", '0);

    // R8: marker bit reaches tap38 only after 38 shifts
    shift_bit(1'b1, 1'b0);
    for (int i = 1; i < 37; i++) shift_bit(1'b0, 1'b0);
    chk_tap("R8", 3'b000);
    shift_bit(1'b0, 1'b0);
    chk_tap("R8", 3'b100);
    load_pulse(1'b0);
    chk_seg("R2", {1'b1, 37'b0});

    // R3: shifts while deselected are dropped
    for (int i = 0; i < 5; i++) shift_bit(1'b1, 1'b1);
    load_pulse(1'b0);
    chk_seg("R3", {1'b1, 37'b0});

    // R6: shifting with load low leaves segments alone
    for (int i = 0; i < 8; i++) shift_bit(1'b1, 1'b0);
    chk_seg("R6", {1'b1, 37'b0});
    load_pulse(1'b1);
    chk_seg("R5", {1'b1, 37'b0});

    // R9: shift and load in the same cycle
    cs_n = 1'b0;
    pre_m = sr_m;
    din = 1'b1; cl = 1'b0; ld = 1'b1;
    wait_n(1);
    chk_seg("R9", pre_m);
    sr_m = {sr_m[W-2:0], 1'b1};
    wait_n(1);
    chk_seg("R9", sr_m);
    ld = 1'b0; seg_m = sr_m;
    wait_n(2);
    cl = 1'b1;
    wait_n(3);
    tap_m = taps_of(sr_m);
    chk_tap("R7", tap_m);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      if (op == 0) load_pulse(logic'($urandom_range(0, 1)));
      else         shift_bit(logic'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0));
      chk_seg("R6", seg_m);
    end
    load_pulse(1'b0);
    chk_seg("R4", sr_m);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule